// File: doc/BRIEF.md
# Debug Trigger Vector and Emulator-Mode Controller

This block turns per-cycle breakpoint match strobes into a debug exception request and picks which of two debug exception vectors the core should take. A PC match leads to vector 13 (offset 0x034). Any other trigger leads to vector 12 (offset 0x030). Triggers can be one-level, where a single condition fires at once. They can also be two-level, where a first condition arms the block and a second condition fires it. Each level has a two-bit source mask that chooses whether PC matches, address/data matches, or either one count as the condition. With both sources enabled, the earliest matching strobe after arming picks the vector. When a PC match and an address match arrive in the same cycle, the non-PC vector wins.

The block also keeps the emulator-mode flag. Taking the debug exception sets the flag. Taking any exception copies the current flag into the fault-status bit that the core stacks (bit 17 of the top frame longword) and clears the flag, unless that exception is itself the debug exception. On return from exception, the flag is reloaded from bit 17 of the stacked longword. A restored flag of 1 shows the debug status code 0xD on the processor-status output for one cycle.

Top module: `dbg_vector_ctl`

## Requirements
- R1: A synchronous active-high reset clears the request, the emulator-mode flag, the stacked fault-status bit, the status code to 0, and the trigger sequencer to its waiting state. A half-completed two-level sequence does not survive reset.
- R2: In one-level mode (mode code 1), the first cycle in which the level-1 condition is met raises the request on the next cycle. Level masks use bit 0 for PC match and bit 1 for address/data match. A PC-only cause gives vector 13; an address cause gives vector 12.
- R3: In two-level mode (mode code 2), a level-1 event only arms the block and raises no request. The first later cycle that meets the level-2 condition raises the request, and the vector comes from that level-2 event.
- R4: With both sources in the level-2 mask, the first matching strobe after arming decides the vector. Strobes after the request are ignored.
- R5: A PC match and an address match in the same cycle, with address enabled in the deciding level's mask, select vector 12.
- R6: The request is high for exactly one cycle. The vector holds its value after the request. Once the block has fired, it raises nothing more until a configuration-load pulse returns it to waiting.
- R7: Mode codes 0 and 3 never raise a request, whatever the strobes do.
- R8: Taking the debug exception (exception strobe with debug flag) sets emulator mode and shows status code 0xD for one cycle. Otherwise the status code is 0.
- R9: Every taken exception stores the emulator-mode flag held just before it into the stacked fault-status output. A non-debug exception clears emulator mode.
- R10: On return, emulator mode takes bit 17 of the stacked longword, and all other bits are ignored. If that bit is 1, the status code is 0xD for one cycle. If it is 0, emulator mode is left and the status stays 0.
- R11: The vector offset output equals the vector number times 4 (0x034 for 13, 0x030 for 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_hit | input | 1 | PC breakpoint match this cycle |
| addr_hit | input | 1 | Address (optionally with data) match this cycle |
| cfg_mode | input | 2 | 0 off, 1 one-level, 2 two-level, 3 off |
| cfg_l1_sel | input | 2 | Level-1 source mask: bit 0 PC, bit 1 address |
| cfg_l2_sel | input | 2 | Level-2 source mask: bit 0 PC, bit 1 address |
| cfg_load | input | 1 | Configuration-load pulse, returns the sequencer to waiting |
| exc_taken | input | 1 | Core takes an exception this cycle |
| exc_debug | input | 1 | The exception taken is the debug exception |
| rte | input | 1 | Return-from-exception executes this cycle |
| rte_frame | input | 32 | Stacked top longword read back on return |
| dbg_req | output | 1 | One-cycle debug exception request |
| dbg_vec | output | 8 | Debug vector number |
| dbg_vec_ofs | output | 10 | Vector table byte offset |
| emu_mode | output | 1 | Emulator-mode flag |
| stk_fs1 | output | 1 | Fault-status bit to stack with the next frame |
| pst | output | 4 | Processor-status code, 0xD on debug entry or restore |

## Verification
A sequencer stuck in the wrong state shows at the ports as a request that is missing, early or repeated. It appears one cycle after the strobe that should or should not fire, so each stimulus step is checked on the very next cycle. A wrong tie or priority decision shows as vector 12 and 13 swapped on that same cycle. A wrong emulator flag shows on emu_mode one cycle after the exception or return. It then shows again in stk_fs1 on the next taken exception, so sequences chain entry, nested exception and return to expose a save or restore error.

// File: rtl/dbgv_pkg.sv
package dbgv_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_ONE  = 2'd1,
    TRIG_TWO  = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_SPENT = 2'd2
  } seq_state_e;

  localparam int SEL_PC   = 0;
  localparam int SEL_ADDR = 1;

  // true when a level's source mask accepts one of this cycle's strobes
  function automatic logic level_match(input logic [1:0] sel,
                                       input logic pc, input logic addr);
    return (sel[SEL_PC] & pc) | (sel[SEL_ADDR] & addr);
  endfunction

  // the non-PC vector wins whenever an enabled address strobe takes part
  function automatic logic addr_cause(input logic [1:0] sel, input logic addr);
    return sel[SEL_ADDR] & addr;
  endfunction

endpackage

// File: rtl/dbgv_trig_seq.sv
module dbgv_trig_seq
  import dbgv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_l1_sel,
  input  logic [1:0] cfg_l2_sel,
  input  logic       cfg_load,
  input  logic       pc_hit,
  input  logic       addr_hit,
  output logic       fire,
  output logic       fire_by_addr,
  output logic       armed
);

  seq_state_e st_q, st_d;
  logic       l1_ev, l2_ev;

  assign l1_ev = level_match(cfg_l1_sel, pc_hit, addr_hit);
  assign l2_ev = level_match(cfg_l2_sel, pc_hit, addr_hit);
  assign armed = (st_q == SEQ_ARMED);

  always_comb begin
    st_d         = st_q;
    fire         = 1'b0;
    fire_by_addr = 1'b0;
    if (cfg_load) begin
      st_d = SEQ_IDLE;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (cfg_mode == TRIG_ONE && l1_ev) begin
            fire         = 1'b1;
            fire_by_addr = addr_cause(cfg_l1_sel, addr_hit);
            st_d         = SEQ_SPENT;
          end else if (cfg_mode == TRIG_TWO && l1_ev) begin
            st_d = SEQ_ARMED;
          end
        end
        SEQ_ARMED: begin
          if (cfg_mode == TRIG_TWO && l2_ev) begin
            fire         = 1'b1;
            fire_by_addr = addr_cause(cfg_l2_sel, addr_hit);
            st_d         = SEQ_SPENT;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_IDLE;
    else     st_q <= st_d;
  end

  // R7: disabled modes never fire
  assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == TRIG_OFF || cfg_mode == TRIG_RSVD) |-> !fire);

  // R3: the arming event of a two-level trigger does not fire
  assert_arm_no_fire_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_IDLE && cfg_mode == TRIG_TWO) |-> !fire);

  // R6: after firing, the sequencer waits for a reload
  assert_spent_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && !cfg_load) |=> !fire);

endmodule

// File: rtl/dbgv_vec_sel.sv
module dbgv_vec_sel #(
  parameter int VEC_W     = 8,
  parameter int VEC_PC    = 13,
  parameter int VEC_NONPC = 12,
  localparam int OFS_W    = VEC_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             fire_by_addr,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic [OFS_W-1:0] vec_ofs
);

  function automatic logic [OFS_W-1:0] vec_to_ofs(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

  logic [VEC_W-1:0] vec_q;
  logic             req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= fire;
      if (fire) vec_q <= fire_by_addr ? VEC_W'(VEC_NONPC) : VEC_W'(VEC_PC);
    end
  end

  assign req     = req_q;
  assign vec     = vec_q;
  assign vec_ofs = vec_to_ofs(vec_q);

  // R5: an address-caused fire (including ties) yields the non-PC vector
  assert_tie_nonpc_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && fire_by_addr) |=> (vec == VEC_W'(VEC_NONPC)));

  // R2: a PC-only fire yields the PC vector
  assert_pc_vector_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && !fire_by_addr) |=> (vec == VEC_W'(VEC_PC)));

  // R6: the vector is stable in the cycle after a request
  assert_vec_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (req && !fire) |=> $stable(vec));

endmodule

// File: rtl/dbgv_emu_ctl.sv
module dbgv_emu_ctl #(
  parameter int          FRAME_W   = 32,
  parameter int          FS1_BIT   = 17,
  parameter int          PST_W     = 4,
  parameter logic [3:0]  PST_DEBUG = 4'hD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_taken,
  input  logic               exc_debug,
  input  logic               rte,
  input  logic [FRAME_W-1:0] rte_frame,
  output logic               emu_mode,
  output logic               stk_fs1,
  output logic [PST_W-1:0]   pst
);

  logic             emu_q, fs1_q;
  logic [PST_W-1:0] pst_q;
  logic             enter_dbg, leave_exc, restore_bit, do_rte;
  logic             unused_frame_bits;

  assign enter_dbg   = exc_taken & exc_debug;
  assign leave_exc   = exc_taken & ~exc_debug;
  assign do_rte      = rte & ~exc_taken;
  assign restore_bit = rte_frame[FS1_BIT];
  assign unused_frame_bits = ^{rte_frame[FRAME_W-1:FS1_BIT+1], rte_frame[FS1_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      emu_q <= 1'b0;
      fs1_q <= 1'b0;
      pst_q <= '0;
    end else begin
      pst_q <= '0;
      if (exc_taken) begin
        fs1_q <= emu_q;
        emu_q <= exc_debug;
        if (exc_debug) pst_q <= PST_W'(PST_DEBUG);
      end else if (rte) begin
        emu_q <= restore_bit;
        if (restore_bit) pst_q <= PST_W'(PST_DEBUG);
      end
    end
  end

  assign emu_mode = emu_q;
  assign stk_fs1  = fs1_q;
  assign pst      = pst_q;

  // R8: debug entry sets emulator mode
  assert_enter_sets_R8: assert property (@(posedge clk) disable iff (rst)
    enter_dbg |=> emu_mode);

  // R8: a nonzero status code only appears while in emulator mode
  assert_pst_in_emu_R8: assert property (@(posedge clk) disable iff (rst)
    (pst != '0) |-> emu_mode);

  // R9: a non-debug exception leaves emulator mode and saves the old flag
  assert_exc_save_R9: assert property (@(posedge clk) disable iff (rst)
    leave_exc |=> (!emu_mode && stk_fs1 == $past(emu_mode)));

  // R10: return restores the flag from the stacked bit
  assert_rte_restore_R10: assert property (@(posedge clk) disable iff (rst)
    do_rte |=> (emu_mode == $past(restore_bit)));

endmodule

// File: rtl/dbg_vector_ctl.sv
module dbg_vector_ctl
  import dbgv_pkg::*;
#(
  parameter int         VEC_W     = 8,
  parameter int         VEC_PC    = 13,
  parameter int         VEC_NONPC = 12,
  parameter int         FRAME_W   = 32,
  parameter int         FS1_BIT   = 17,
  parameter int         PST_W     = 4,
  parameter logic [3:0] PST_DEBUG = 4'hD,
  localparam int        OFS_W     = VEC_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pc_hit,
  input  logic               addr_hit,
  input  logic [1:0]         cfg_mode,
  input  logic [1:0]         cfg_l1_sel,
  input  logic [1:0]         cfg_l2_sel,
  input  logic               cfg_load,
  input  logic               exc_taken,
  input  logic               exc_debug,
  input  logic               rte,
  input  logic [FRAME_W-1:0] rte_frame,
  output logic               dbg_req,
  output logic [VEC_W-1:0]   dbg_vec,
  output logic [OFS_W-1:0]   dbg_vec_ofs,
  output logic               emu_mode,
  output logic               stk_fs1,
  output logic [PST_W-1:0]   pst
);

  logic seq_fire, seq_by_addr, seq_armed;

  dbgv_trig_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode     (cfg_mode),
    .cfg_l1_sel   (cfg_l1_sel),
    .cfg_l2_sel   (cfg_l2_sel),
    .cfg_load     (cfg_load),
    .pc_hit       (pc_hit),
    .addr_hit     (addr_hit),
    .fire         (seq_fire),
    .fire_by_addr (seq_by_addr),
    .armed        (seq_armed)
  );

  dbgv_vec_sel #(
    .VEC_W     (VEC_W),
    .VEC_PC    (VEC_PC),
    .VEC_NONPC (VEC_NONPC)
  ) u_vec (
    .clk          (clk),
    .rst          (rst),
    .fire         (seq_fire),
    .fire_by_addr (seq_by_addr),
    .req          (dbg_req),
    .vec          (dbg_vec),
    .vec_ofs      (dbg_vec_ofs)
  );

  dbgv_emu_ctl #(
    .FRAME_W   (FRAME_W),
    .FS1_BIT   (FS1_BIT),
    .PST_W     (PST_W),
    .PST_DEBUG (PST_DEBUG)
  ) u_emu (
    .clk       (clk),
    .rst       (rst),
    .exc_taken (exc_taken),
    .exc_debug (exc_debug),
    .rte       (rte),
    .rte_frame (rte_frame),
    .emu_mode  (emu_mode),
    .stk_fs1   (stk_fs1),
    .pst       (pst)
  );

  // R6: the request is a single-cycle pulse
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dbg_req |=> !dbg_req);

  // R3: a request never coexists with a still-armed sequencer
  assert_req_not_armed_R3: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> !seq_armed);

  // R11: the offset tracks the vector number in steps of four bytes
  assert_ofs_scale_R11: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> (dbg_vec_ofs[1:0] == 2'b00 && dbg_vec_ofs[OFS_W-1:2] == dbg_vec));

endmodule

// File: tb/dbg_vector_ctl_test.sv
`timescale 1ns/1ps
module dbg_vector_ctl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        pc_hit, addr_hit;
  logic [1:0]  cfg_mode, cfg_l1_sel, cfg_l2_sel;
  logic        cfg_load, exc_taken, exc_debug, rte;
  logic [31:0] rte_frame;
  logic        dbg_req, emu_mode, stk_fs1;
  logic [7:0]  dbg_vec;
  logic [9:0]  dbg_vec_ofs;
  logic [3:0]  pst;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dbg_vector_ctl uut (
    .clk(clk), .rst(rst), .pc_hit(pc_hit), .addr_hit(addr_hit),
    .cfg_mode(cfg_mode), .cfg_l1_sel(cfg_l1_sel), .cfg_l2_sel(cfg_l2_sel),
    .cfg_load(cfg_load), .exc_taken(exc_taken), .exc_debug(exc_debug),
    .rte(rte), .rte_frame(rte_frame), .dbg_req(dbg_req), .dbg_vec(dbg_vec),
    .dbg_vec_ofs(dbg_vec_ofs), .emu_mode(emu_mode), .stk_fs1(stk_fs1), .pst(pst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // row: mode, l1 mask, l2 mask, three strobe steps {addr,pc}, expected req per step, vector
  localparam int NROWS = 11;
  localparam logic [22:0] ROWS [NROWS] = '{
    {2'd1, 2'b01, 2'b00, 2'b01, 2'b01, 2'b00, 3'b100, 8'd13}, // R2 pc, then spent R6
    {2'd1, 2'b10, 2'b00, 2'b01, 2'b10, 2'b10, 3'b010, 8'd12}, // R2 addr, pc masked
    {2'd1, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 3'b100, 8'd12}, // R5 tie one-level
    {2'd2, 2'b01, 2'b11, 2'b01, 2'b01, 2'b10, 3'b010, 8'd13}, // R4 pc first
    {2'd2, 2'b10, 2'b11, 2'b10, 2'b10, 2'b01, 3'b010, 8'd12}, // R4 addr first
    {2'd2, 2'b01, 2'b11, 2'b01, 2'b11, 2'b00, 3'b010, 8'd12}, // R5 tie two-level
    {2'd2, 2'b01, 2'b10, 2'b01, 2'b01, 2'b10, 3'b001, 8'd12}, // R3 level-2 source only
    {2'd0, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 3'b000, 8'd0 }, // R7 off
    {2'd2, 2'b10, 2'b01, 2'b00, 2'b10, 2'b01, 3'b001, 8'd13}, // R3 second event picks
    {2'd2, 2'b11, 2'b01, 2'b11, 2'b11, 2'b00, 3'b010, 8'd13}, // R5 addr masked at level 2
    {2'd3, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 3'b000, 8'd0 }  // R7 reserved code
  };

  task automatic step(input logic p, input logic a);
    pc_hit = p; addr_hit = a;
    @(negedge clk);
    pc_hit = 1'b0; addr_hit = 1'b0;
  endtask

  task automatic load_cfg(input logic [1:0] m, input logic [1:0] s1, input logic [1:0] s2);
    cfg_mode = m; cfg_l1_sel = s1; cfg_l2_sel = s2; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic exc(input logic dbg);
    exc_taken = 1'b1; exc_debug = dbg;
    @(negedge clk);
    exc_taken = 1'b0; exc_debug = 1'b0;
  endtask

  task automatic do_rte(input logic [31:0] frame);
    rte = 1'b1; rte_frame = frame;
    @(negedge clk);
    rte = 1'b0; rte_frame = '0;
  endtask

  initial begin
    rst = 1'b1; pc_hit = 0; addr_hit = 0; cfg_mode = 0; cfg_l1_sel = 0;
    cfg_l2_sel = 0; cfg_load = 0; exc_taken = 0; exc_debug = 0; rte = 0; rte_frame = '0;
    repeat (3) @(negedge clk);
    chk("R1 req after reset", dbg_req, 0);
    chk("R1 emu after reset", emu_mode, 0);
    chk("R1 pst after reset", pst, 0);
    chk("R1 fs1 after reset", stk_fs1, 0);
    rst = 1'b0;

    for (int r = 0; r < NROWS; r++) begin
      logic [22:0] row;
      row = ROWS[r];
      load_cfg(row[22:21], row[20:19], row[18:17]);
      for (int s = 0; s < 3; s++) begin
        logic [1:0] h;
        logic       exp_req;
        h = row[16 - 2*s -: 2];
        exp_req = row[10 - s];
        step(h[0], h[1]);
        chk($sformatf("R2/R3/R4/R7 row %0d step %0d req", r, s), dbg_req, exp_req);
        if (exp_req) begin
          chk($sformatf("R5 row %0d vector", r), dbg_vec, row[7:0]);
          chk($sformatf("R11 row %0d offset", r), dbg_vec_ofs, row[7:0] * 4);
        end
      end
      if (row[10:8] != 3'b000)
        chk($sformatf("R6 row %0d vector held", r), dbg_vec, row[7:0]);
    end

    // R6: spent until reload, then fires again
    load_cfg(2'd1, 2'b01, 2'b00);
    step(1, 0); chk("R6 first fire", dbg_req, 1);
    step(1, 0); chk("R6 no refire", dbg_req, 0);
    step(1, 0); chk("R6 still spent", dbg_req, 0);
    load_cfg(2'd1, 2'b01, 2'b00);
    step(1, 0); chk("R6 refire after reload", dbg_req, 1);
    chk("R11 pc offset 0x034", dbg_vec_ofs, 10'h034);

    // R1: reset discards an armed two-level sequence
    load_cfg(2'd2, 2'b01, 2'b01);
    step(1, 0); chk("R3 arming no req", dbg_req, 0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    step(1, 0); chk("R1 armed state cleared", dbg_req, 0);
    step(1, 0); chk("R1 fires only after new arming", dbg_req, 1);

    // emulator mode
    exc(1'b1);
    chk("R8 emu set on debug entry", emu_mode, 1);
    chk("R8 pst 0xD on entry", pst, 4'hD);
    @(negedge clk);
    chk("R8 pst back to 0", pst, 0);
    chk("R8 emu stays set", emu_mode, 1);
    exc(1'b0);
    chk("R9 fs1 saved as 1", stk_fs1, 1);
    chk("R9 emu cleared", emu_mode, 0);
    chk("R9 pst 0 on normal exception", pst, 0);
    do_rte(32'h0002_0000);
    chk("R10 emu restored", emu_mode, 1);
    chk("R10 pst 0xD on restore", pst, 4'hD);
    @(negedge clk);
    chk("R10 pst one cycle", pst, 0);
    do_rte(32'hFFFD_FFFF);
    chk("R10 bit17 clear leaves emu", emu_mode, 0);
    chk("R10 other bits ignored pst", pst, 0);
    exc(1'b0);
    chk("R9 fs1 saved as 0", stk_fs1, 0);
    exc(1'b1);
    exc(1'b1);
    chk("R9 nested debug saves 1", stk_fs1, 1);
    chk("R8 nested debug keeps emu", emu_mode, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset clears emu", emu_mode, 0);
    chk("R1 reset clears fs1", stk_fs1, 0);
    chk("R1 reset clears pst", pst, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule